// File: doc/BRIEF.md
# PLL Divider Word Calculator

This block turns a requested PLL output frequency into the two settings a fractional-N synthesizer needs. The first is a feedback divider word with seven integer bits and a configurable number of fraction bits. The second is a power-of-two post-divider exponent. The exponent is chosen so that the oscillator runs at or above a fixed floor. The block then reports the frequency those settings actually give.

A second mode runs the other way. It takes a divider word and a post-divider exponent and reports the resulting output frequency. It rounds up where the fraction bits are dropped and again at the post-division.

Each operation is framed by a single-cycle start and a single-cycle done. The forward path divides with a restoring shift-subtract divider, one quotient bit per cycle. The readback path needs no divider, because dividing by a power of two with rounding up is a shift.

Top module: `pllw_calc`

## Requirements
- R1: In forward mode (`op_rb_i` = 0), a requested frequency above `vco_max_i` is replaced by `vco_max_i` before any further step.
- R2: The forward exponent is the smallest e in 0..4 for which the clamped frequency times 2^e is at least 1,000,000,000. If no e qualifies, e is 4.
- R3: The fraction-bit count is `word_width_i` − 7 when the width is above 7, and 0 otherwise. A width above 32 is treated as 32. The forward word is the low 32 bits of ((clamped frequency << e) << fraction bits) / `ref_freq_i`, truncated.
- R4: The reported frequency is computed in four steps:
  - Form v = reference × word.
  - Shift v right by the fraction-bit count.
  - Add 1 if any bit shifted out was nonzero.
  - Divide by 2^e rounding up, and report the low 32 bits.
  
  In forward mode the reported frequency uses the computed word and exponent.
- R5: In readback mode (`op_rb_i` = 1), bits of `word_in_i` at positions at or above the configured width are cleared. The cleared value is reported on `word_o`. All three bits of `exp_in_i` (0..7) are used as the exponent.
- R6: A forward request with `ref_freq_i` = 0 ends one cycle after the start edge with `done_o` and `err_o` both high. `word_o`, `exp_o` and `freq_o` keep their previous values. `err_o` clears at the next accepted start. A readback with reference 0 is not an error and reports 0.
- R7: `done_o` is high for exactly one cycle. It rises 66 clock edges after the start edge for a forward operation and 1 edge after for a readback. `busy_o` is high from the start edge until the edge that raises `done_o`.
- R8: A start while `busy_o` is high is ignored. A start during the `done_o` cycle is accepted.
- R9: After reset, `busy_o`, `done_o` and `err_o` are 0, and `word_o`, `exp_o` and `freq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launches one operation when idle |
| op_rb_i | input | 1 | 0 = forward calculation, 1 = readback |
| freq_req_i | input | 32 | Requested output frequency |
| ref_freq_i | input | 32 | Reference frequency |
| vco_max_i | input | 32 | Upper limit applied to the request |
| word_width_i | input | 6 | Configured divider word width in bits |
| word_in_i | input | 32 | Divider word for readback |
| exp_in_i | input | 3 | Post-divider exponent for readback |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero reference on a forward request |
| word_o | output | 32 | Divider word |
| exp_o | output | 3 | Post-divider exponent |
| freq_o | output | 32 | Achieved or read-back frequency |

## Verification
Two events can share a cycle: a new start can arrive in the very cycle that the previous operation raises its done pulse. The bench provokes this by driving start in the cycle where it first sees done. It then judges the case on three points:
- the first result is intact;
- done of the first operation stays one cycle wide;
- the second operation completes with its own expected values and latency.

The bench also tests the opposite case. A start raised in the middle of a forward division must be ignored: exactly one done pulse follows, carrying the first request's values.

// File: rtl/pllw_pkg.sv
package pllw_pkg;

    localparam int EXP_W = 3;

    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_DIV  = 2'd1,
        PW_RB   = 2'd2,
        PW_FAIL = 2'd3
    } pw_state_e;

endpackage

// File: rtl/pllw_prep.sv
module pllw_prep #(
    parameter int          FREQ_W    = 32,
    parameter int          WORD_W    = 32,
    parameter int          PROD_W    = 64,
    parameter int          INT_BITS  = 7,
    parameter int          EXP_MAX   = 4,
    parameter logic [63:0] VCO_FLOOR = 64'd1_000_000_000,
    localparam int         WW_W      = $clog2(WORD_W + 1)
) (
    input  logic [FREQ_W-1:0]          freq_req_i,
    input  logic [FREQ_W-1:0]          vco_max_i,
    input  logic [WW_W-1:0]            width_i,
    output logic [pllw_pkg::EXP_W-1:0] exp_o,
    output logic [WW_W-1:0]            frac_o,
    output logic [PROD_W-1:0]          dividend_o,
    output logic [WORD_W-1:0]          word_mask_o
);
    import pllw_pkg::*;

    logic [FREQ_W-1:0] f_clamp;
    logic [WW_W-1:0]   w_eff;
    logic              found;

    assign f_clamp = (freq_req_i > vco_max_i) ? vco_max_i : freq_req_i;
    assign w_eff   = (width_i > WW_W'(WORD_W)) ? WW_W'(WORD_W) : width_i;
    assign frac_o  = (w_eff > WW_W'(INT_BITS)) ? (w_eff - WW_W'(INT_BITS)) : '0;

    always_comb begin
        exp_o = EXP_W'(EXP_MAX);
        found = 1'b0;
        for (int e = 0; e <= EXP_MAX; e++) begin
            if (!found && ((PROD_W'(f_clamp) << e) >= PROD_W'(VCO_FLOOR))) begin
                exp_o = EXP_W'(e);
                found = 1'b1;
            end
        end
    end

    assign dividend_o  = (PROD_W'(f_clamp) << exp_o) << frac_o;
    assign word_mask_o = (w_eff >= WW_W'(WORD_W)) ? '1
                       : WORD_W'((PROD_W'(1) << w_eff) - PROD_W'(1));

endmodule

// File: rtl/pllw_div.sv
module pllw_div #(
    parameter int  N_W   = 64,
    parameter int  D_W   = 32,
    parameter int  Q_W   = 32,
    localparam int CNT_W = $clog2(N_W + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic [N_W-1:0] dividend_i,
    input  logic [D_W-1:0] divisor_i,
    output logic           fin_o,
    output logic [Q_W-1:0] quot_o
);
    logic [N_W-1:0]   q_r;
    logic [D_W-1:0]   rem_r;
    logic [D_W-1:0]   div_r;
    logic [CNT_W-1:0] cnt_r;
    logic [D_W:0]     trial;
    logic             take;

    assign trial = {rem_r, q_r[N_W-1]};
    assign take  = trial >= {1'b0, div_r};

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r   <= '0;
            rem_r <= '0;
            div_r <= '0;
            cnt_r <= '0;
            fin_o <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            if (load_i) begin
                q_r   <= dividend_i;
                rem_r <= '0;
                div_r <= divisor_i;
                cnt_r <= CNT_W'(N_W);
            end else if (cnt_r != '0) begin
                q_r   <= {q_r[N_W-2:0], take};
                rem_r <= take ? D_W'(trial - {1'b0, div_r}) : D_W'(trial);
                cnt_r <= cnt_r - CNT_W'(1);
                if (cnt_r == CNT_W'(1)) begin
                    fin_o <= 1'b1;
                end
            end
        end
    end

    assign quot_o = Q_W'(q_r);

endmodule

// File: rtl/pllw_rb.sv
module pllw_rb #(
    parameter int  FREQ_W = 32,
    parameter int  WORD_W = 32,
    parameter int  PROD_W = 64,
    localparam int WW_W   = $clog2(WORD_W + 1)
) (
    input  logic [FREQ_W-1:0]          ref_i,
    input  logic [WORD_W-1:0]          word_i,
    input  logic [WW_W-1:0]            frac_i,
    input  logic [pllw_pkg::EXP_W-1:0] exp_i,
    output logic [FREQ_W-1:0]          freq_o
);
    logic [PROD_W-1:0] vco;
    logic [PROD_W-1:0] low_mask;
    logic              bump;
    logic [PROD_W+1:0] vco_sh;
    logic [PROD_W+1:0] pdiv;
    logic [PROD_W+1:0] ceil_q;

    assign vco      = PROD_W'(ref_i) * PROD_W'(word_i);
    assign low_mask = (PROD_W'(1) << frac_i) - PROD_W'(1);
    assign bump     = |(vco & low_mask);
    assign vco_sh   = (PROD_W+2)'(vco >> frac_i) + (PROD_W+2)'(bump);
    assign pdiv     = (PROD_W+2)'(1) << exp_i;
    assign ceil_q   = (vco_sh + pdiv - (PROD_W+2)'(1)) >> exp_i;
    assign freq_o   = FREQ_W'(ceil_q);

endmodule

// File: rtl/pllw_calc.sv
module pllw_calc #(
    parameter int          FREQ_W    = 32,
    parameter int          WORD_W    = 32,
    parameter int          PROD_W    = 64,
    parameter int          INT_BITS  = 7,
    parameter int          EXP_MAX   = 4,
    parameter logic [63:0] VCO_FLOOR = 64'd1_000_000_000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic                          op_rb_i,
    input  logic [FREQ_W-1:0]             freq_req_i,
    input  logic [FREQ_W-1:0]             ref_freq_i,
    input  logic [FREQ_W-1:0]             vco_max_i,
    input  logic [$clog2(WORD_W+1)-1:0]   word_width_i,
    input  logic [WORD_W-1:0]             word_in_i,
    input  logic [pllw_pkg::EXP_W-1:0]    exp_in_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          err_o,
    output logic [WORD_W-1:0]             word_o,
    output logic [pllw_pkg::EXP_W-1:0]    exp_o,
    output logic [FREQ_W-1:0]             freq_o
);
    import pllw_pkg::*;

    localparam int WW_W = $clog2(WORD_W + 1);

    pw_state_e          state_r;
    logic [FREQ_W-1:0]  ref_r;
    logic [WW_W-1:0]    frac_r;
    logic [EXP_W-1:0]   exp_c;
    logic [WW_W-1:0]    frac_c;
    logic [PROD_W-1:0]  dividend_c;
    logic [WORD_W-1:0]  mask_c;
    logic [WORD_W-1:0]  quot;
    logic [FREQ_W-1:0]  rb_freq;
    logic               accept;
    logic               div_load;
    logic               div_fin;

    assign accept   = start_i && (state_r == PW_IDLE);
    assign div_load = accept && !op_rb_i && (ref_freq_i != '0);
    assign busy_o   = (state_r != PW_IDLE);

    pllw_prep #(
        .FREQ_W(FREQ_W), .WORD_W(WORD_W), .PROD_W(PROD_W),
        .INT_BITS(INT_BITS), .EXP_MAX(EXP_MAX), .VCO_FLOOR(VCO_FLOOR)
    ) prep_i (
        .freq_req_i (freq_req_i),
        .vco_max_i  (vco_max_i),
        .width_i    (word_width_i),
        .exp_o      (exp_c),
        .frac_o     (frac_c),
        .dividend_o (dividend_c),
        .word_mask_o(mask_c)
    );

    pllw_div #(.N_W(PROD_W), .D_W(FREQ_W), .Q_W(WORD_W)) div_i (
        .clk       (clk),
        .rst       (rst),
        .load_i    (div_load),
        .dividend_i(dividend_c),
        .divisor_i (ref_freq_i),
        .fin_o     (div_fin),
        .quot_o    (quot)
    );

    pllw_rb #(.FREQ_W(FREQ_W), .WORD_W(WORD_W), .PROD_W(PROD_W)) rb_i (
        .ref_i (ref_r),
        .word_i(word_o),
        .frac_i(frac_r),
        .exp_i (exp_o),
        .freq_o(rb_freq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_r <= PW_IDLE;
            ref_r   <= '0;
            frac_r  <= '0;
            word_o  <= '0;
            exp_o   <= '0;
            freq_o  <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_r)
                PW_IDLE: begin
                    if (accept) begin
                        err_o <= 1'b0;
                        if (op_rb_i) begin
                            ref_r   <= ref_freq_i;
                            frac_r  <= frac_c;
                            word_o  <= word_in_i & mask_c;
                            exp_o   <= exp_in_i;
                            state_r <= PW_RB;
                        end else if (ref_freq_i == '0) begin
                            state_r <= PW_FAIL;
                        end else begin
                            ref_r   <= ref_freq_i;
                            frac_r  <= frac_c;
                            exp_o   <= exp_c;
                            state_r <= PW_DIV;
                        end
                    end
                end
                PW_DIV: begin
                    if (div_fin) begin
                        word_o  <= quot;
                        state_r <= PW_RB;
                    end
                end
                PW_RB: begin
                    freq_o  <= rb_freq;
                    done_o  <= 1'b1;
                    state_r <= PW_IDLE;
                end
                PW_FAIL: begin
                    done_o  <= 1'b1;
                    err_o   <= 1'b1;
                    state_r <= PW_IDLE;
                end
                default: state_r <= PW_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pllw_calc_chk.sv
module pllw_calc_chk #(
    parameter int FREQ_W  = 32,
    parameter int WORD_W  = 32,
    parameter int EXP_MAX = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       start_i,
    input logic                       op_rb_i,
    input logic [FREQ_W-1:0]          ref_freq_i,
    input logic                       busy_o,
    input logic                       done_o,
    input logic                       err_o,
    input logic [WORD_W-1:0]          word_o,
    input logic [pllw_pkg::EXP_W-1:0] exp_o
);
    logic op_rb_q;
    logic ref_zero_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_rb_q    <= 1'b0;
            ref_zero_q <= 1'b0;
        end else if (start_i && !busy_o) begin
            op_rb_q    <= op_rb_i;
            ref_zero_q <= (ref_freq_i == '0);
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R7

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o); // R8

    AST_EXP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o && !op_rb_q) |-> (int'(exp_o) <= EXP_MAX)); // R2

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (ref_zero_q && !op_rb_q)); // R6

    AST_ERR_HOLDS_OUT: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> ($stable(word_o) && $stable(exp_o))); // R6

endmodule

bind pllw_calc pllw_calc_chk #(
    .FREQ_W(FREQ_W), .WORD_W(WORD_W), .EXP_MAX(EXP_MAX)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .op_rb_i   (op_rb_i),
    .ref_freq_i(ref_freq_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .word_o    (word_o),
    .exp_o     (exp_o)
);

// File: tb/pllw_calc_tb_top.sv
module pllw_calc_tb_top;

    localparam int LAT_FWD = 66;
    localparam int LAT_RB  = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        op_rb_i = 1'b0;
    logic [31:0] freq_req_i = '0;
    logic [31:0] ref_freq_i = '0;
    logic [31:0] vco_max_i = '0;
    logic [5:0]  word_width_i = '0;
    logic [31:0] word_in_i = '0;
    logic [2:0]  exp_in_i = '0;
    logic        busy_o, done_o, err_o;
    logic [31:0] word_o;
    logic [2:0]  exp_o;
    logic [31:0] freq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pllw_calc dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .op_rb_i(op_rb_i),
        .freq_req_i(freq_req_i), .ref_freq_i(ref_freq_i), .vco_max_i(vco_max_i),
        .word_width_i(word_width_i), .word_in_i(word_in_i), .exp_in_i(exp_in_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .word_o(word_o), .exp_o(exp_o), .freq_o(freq_o)
    );

    task automatic chk(input bit ok, input string req,
                       input longint unsigned act, input longint unsigned expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int frac_of(input int w);
        int we = (w > 32) ? 32 : w;
        return (we > 7) ? we - 7 : 0;
    endfunction

    function automatic logic [31:0] mdl_rb(input logic [31:0] r, input logic [31:0] w,
                                           input int fb, input int e);
        logic [63:0] v;
        logic [65:0] s;
        v = 64'(r) * 64'(w);
        s = 66'(v >> fb);
        if (fb != 0 && (v & ((64'd1 << fb) - 64'd1)) != 64'd0) s = s + 66'd1;
        s = (s + (66'd1 << e) - 66'd1) >> e;
        return s[31:0];
    endfunction

    task automatic mdl_fwd(input logic [31:0] f, input logic [31:0] r, input logic [31:0] vm,
                           input int w, output logic [31:0] wd, output int e,
                           output logic [31:0] fo);
        logic [31:0] fc;
        logic [63:0] q;
        bit          got;
        fc  = (f > vm) ? vm : f;
        e   = 4;
        got = 0;
        for (int i = 0; i <= 4; i++)
            if (!got && ((64'(fc) << i) >= 64'd1000000000)) begin e = i; got = 1; end
        q  = ((64'(fc) << e) << frac_of(w)) / 64'(r);
        wd = q[31:0];
        fo = mdl_rb(r, wd, frac_of(w), e);
    endtask

    task automatic launch(input bit rb, input logic [31:0] f, input logic [31:0] r,
                          input logic [31:0] vm, input int w,
                          input logic [31:0] wi, input logic [2:0] ei);
        op_rb_i = rb; freq_req_i = f; ref_freq_i = r; vco_max_i = vm;
        word_width_i = 6'(w); word_in_i = wi; exp_in_i = ei;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done_o && lat < 300) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        if (!done_o) chk(0, "R7 done timeout", 0, 1);
    endtask

    task automatic t_reset();
        chk(busy_o == 0 && done_o == 0 && err_o == 0, "R9 flags", {busy_o, done_o, err_o}, 0);
        chk(word_o == 0 && exp_o == 0 && freq_o == 0, "R9 outputs", word_o, 0);
    endtask

    task automatic t_fwd(input string req, input logic [31:0] f, input logic [31:0] r,
                         input logic [31:0] vm, input int w);
        logic [31:0] ew, ef;
        int ee, lat;
        mdl_fwd(f, r, vm, w, ew, ee, ef);
        launch(0, f, r, vm, w, '0, '0);
        wait_done(lat);
        chk(lat == LAT_FWD, {req, " R7 latency"}, lat, LAT_FWD);
        chk(exp_o == 3'(ee), {req, " R2 exponent"}, exp_o, ee);
        chk(word_o == ew, {req, " R3 word"}, word_o, ew);
        chk(freq_o == ef, {req, " R4 freq"}, freq_o, ef);
        chk(err_o == 0, {req, " R6 no err"}, err_o, 0);
        @(posedge clk); @(negedge clk);
        chk(done_o == 0, {req, " R7 single pulse"}, done_o, 0);
    endtask

    task automatic t_rb(input string req, input logic [31:0] r, input logic [31:0] wi,
                        input int w, input logic [2:0] ei,
                        input logic [31:0] ewd, input logic [31:0] ef);
        int lat;
        launch(1, '0, r, '0, w, wi, ei);
        wait_done(lat);
        chk(lat == LAT_RB, {req, " R7 latency"}, lat, LAT_RB);
        chk(word_o == ewd, {req, " R5 word"}, word_o, ewd);
        chk(exp_o == ei, {req, " R5 exp"}, exp_o, ei);
        chk(freq_o == ef, {req, " R4 freq"}, freq_o, ef);
        chk(err_o == 0, {req, " R6 no err"}, err_o, 0);
    endtask

    task automatic t_err();
        logic [31:0] w0, f0;
        logic [2:0]  e0;
        int lat;
        w0 = word_o; e0 = exp_o; f0 = freq_o;
        launch(0, 32'd400_000_000, 32'd0, 32'd3_000_000_000, 22, '0, '0);
        wait_done(lat);
        chk(lat == 1, "R6 err latency", lat, 1);
        chk(err_o == 1, "R6 err set", err_o, 1);
        chk(word_o == w0 && exp_o == e0 && freq_o == f0, "R6 outputs hold", word_o, w0);
        @(posedge clk); @(negedge clk);
        chk(err_o == 1 && done_o == 0, "R6 err persists", err_o, 1);
        t_rb("R6 rb zero ref", 32'd0, 32'd1234, 22, 3'd1, 32'd1234, 32'd0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] ew, ef;
        int ee, dones;
        mdl_fwd(32'd600_000_000, 32'd26_000_000, 32'd3_000_000_000, 20, ew, ee, ef);
        launch(0, 32'd600_000_000, 32'd26_000_000, 32'd3_000_000_000, 20, '0, '0);
        repeat (10) begin @(posedge clk); @(negedge clk); end
        launch(1, 32'd90_000_000, 32'd7, 32'd100, 9, 32'd55, 3'd6);
        dones = 0;
        for (int i = 0; i < 100; i++) begin
            if (done_o) begin
                dones++;
                chk(word_o == ew, "R8 ignored start word", word_o, ew);
                chk(freq_o == ef, "R8 ignored start freq", freq_o, ef);
            end
            @(posedge clk); @(negedge clk);
        end
        chk(dones == 1, "R8 one done only", dones, 1);
    endtask

    task automatic t_back2back();
        logic [31:0] ew, ef;
        int ee, lat;
        mdl_fwd(32'd1_200_000_000, 32'd25_000_000, 32'd3_000_000_000, 24, ew, ee, ef);
        launch(0, 32'd1_200_000_000, 32'd25_000_000, 32'd3_000_000_000, 24, '0, '0);
        wait_done(lat);
        chk(word_o == ew && exp_o == 3'(ee), "R8 first of pair", word_o, ew);
        launch(1, '0, 32'd3, '0, 8, 32'd5, 3'd0);
        chk(done_o == 0, "R7 done one cycle in pair", done_o, 0);
        wait_done(lat);
        chk(lat == LAT_RB, "R8 second of pair latency", lat, LAT_RB);
        chk(freq_o == 32'd8, "R8 second of pair freq", freq_o, 8);
    endtask

    initial begin
        #(5.0 * 150000);
        chk(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fwd("R3 base",      32'd1_500_000_000, 32'd26_000_000, 32'd3_000_000_000, 22);
        t_fwd("R2 x4",        32'd300_000_000,   32'd26_000_000, 32'd3_000_000_000, 22);
        t_fwd("R2 none",      32'd50_000_000,    32'd26_000_000, 32'd3_000_000_000, 22);
        t_fwd("R2 edge250",   32'd250_000_000,   32'd26_000_000, 32'd3_000_000_000, 22);
        t_fwd("R2 edge1000",  32'd1_000_000_000, 32'd26_000_000, 32'd3_000_000_000, 31);
        t_fwd("R1 clamp",     32'd3_500_000_000, 32'd26_000_000, 32'd2_000_000_000, 22);
        t_fwd("R3 width7",    32'd700_000_000,   32'd25_000_000, 32'd3_000_000_000, 7);
        t_fwd("R3 width5",    32'd700_000_000,   32'd25_000_000, 32'd3_000_000_000, 5);
        t_fwd("R3 width32",   32'd1_100_000_000, 32'd40_000_000, 32'd3_000_000_000, 32);
        t_fwd("R3 width40",   32'd1_100_000_000, 32'd40_000_000, 32'd3_000_000_000, 40);
        t_rb("R5 mask",  32'd26_000_000, 32'hFFC1_2345, 22, 3'd7, 32'h0001_2345,
             mdl_rb(32'd26_000_000, 32'h0001_2345, 15, 7));
        t_rb("R4 roundup", 32'd3, 32'd5, 8, 3'd0, 32'd5, 32'd8);
        t_rb("R4 ceil",    32'd3, 32'd7, 9, 3'd2, 32'd7, 32'd2);
        t_rb("R4 exact",   32'd4, 32'd8, 9, 3'd3, 32'd8, 32'd1);
        t_err();
        chk(err_o == 0, "R6 err cleared by next start", err_o, 0);
        t_busy_ignore();
        t_back2back();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule